// File: doc/BRIEF.md
# Store Write Buffer with Read Hazard Drain

This block sits between a processor's store port and a memory bus that is 16 bits wide. The processor hands it a 32-bit word and a word address, and the block takes the store in a single cycle. It places the store in a small first-in, first-out queue, so the processor can continue at once. Whenever the bus grants access, the block writes out the oldest entry in two halves: the low half goes in one granted cycle and the high half in the next granted cycle. The entry leaves the queue after its high half is accepted.

Two cases stall the processor. The first is a read whose address matches any store still in the queue, including the entry whose halves are on the bus at that moment. Such a read must not see stale memory, so the processor waits until every queued entry has reached memory, not only the matching one. The second is a store that arrives while all slots are occupied. That store waits for a free slot, but it goes in without delay in a cycle where the head entry finishes. The processor issues at most one request per cycle, either a store or a read.

Top module: `store_write_buffer`

## Requirements
- R1: After reset the queue is empty: `idle` is 1, `bus_req` is 0 and `cpu_stall` is 0.
- R2: A store that arrives while at least one slot is free is accepted in the same cycle with `cpu_stall` at 0. Entries reach the bus in the order they were stored.
- R3: While the queue holds an entry, `bus_req` is 1 and the bus carries the oldest entry's word address. With `bus_half` = 0 it carries data bits 15:0, and with `bus_half` = 1 it carries bits 31:16. The low half is sent first, and the entry retires on the granted cycle that carries the high half.
- R4: A cycle with `bus_req` = 1 and `bus_gnt` = 0 moves nothing. In the next cycle the address, the half select and the data are unchanged.
- R5: A read whose address equals that of any queued entry stalls. If the read keeps requesting, it stays stalled until the queue is fully empty, even after the matching entry has retired.
- R6: A read whose address matches no queued entry does not stall, and no earlier forced drain is pending for it.
- R7: A store that arrives with all DEPTH slots full stalls, except in a cycle where the head entry's high half is granted. In that cycle the store is accepted without a stall.
- R8: `idle` is 1 exactly when no entry is queued and no transfer is under way. It is never 1 together with `bus_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_req | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | 32 | Store data |
| rd_req | input | 1 | Read request, to be checked against queued stores |
| rd_addr | input | AW | Read word address |
| cpu_stall | output | 1 | Current request must be held and retried |
| bus_req | output | 1 | A half-word write is offered on the bus |
| bus_addr | output | AW | Word address of the head entry |
| bus_half | output | 1 | 0 = low half, 1 = high half |
| bus_wdata | output | 16 | Half-word being written |
| bus_gnt | input | 1 | Bus accepts the offered half this cycle |
| idle | output | 1 | Queue empty and bus quiet |

## Verification
The first pattern is a run of stores with the bus granted every cycle. It shows that halves go out low then high, back to back, and that order is preserved. The second pattern fills the queue with the grant held low, and it separates a plain full stall from the cycle where a store slips in as the head retires. Reads are tried three ways: against an address that is absent, against a middle entry, and against the entry whose halves are on the bus. These show a miss passing straight through and a hit holding until the queue is empty rather than until its own entry is gone. A long random mix with a sparse grant and a small address set then exercises all of these cases together against the cycle-by-cycle model.

// File: rtl/store_write_buffer.sv
module store_write_buffer #(
  parameter int DEPTH = 8,
  parameter int AW    = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_req,
  input  logic [AW-1:0] st_addr,
  input  logic [31:0]   st_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          cpu_stall,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_half,
  output logic [15:0]   bus_wdata,
  input  logic          bus_gnt,
  output logic          idle
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [31:0]      data_q [DEPTH];
  logic [DEPTH-1:0] vld, vld_n;
  logic [PW-1:0]    head, tail;
  logic             half, drain, hit, full, retire, push;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = &vld;
  assign idle      = ~|vld;
  assign bus_req   = ~idle;
  assign bus_addr  = addr_q[head];
  assign bus_half  = half;
  assign bus_wdata = half ? data_q[head][31:16] : data_q[head][15:0];
  assign retire    = bus_req & bus_gnt & half;
  assign push      = st_req & (~full | retire);
  assign cpu_stall = (rd_req & (hit | drain)) | (st_req & full & ~retire);

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && addr_q[i] == rd_addr) hit = 1'b1;
  end

  always_comb begin
    vld_n = vld;
    if (retire) vld_n[head] = 1'b0;
    if (push)   vld_n[tail] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      head  <= '0;
      tail  <= '0;
      half  <= 1'b0;
      drain <= 1'b0;
    end else begin
      vld   <= vld_n;
      drain <= (drain | (rd_req & hit)) & (|vld_n);
      if (bus_req && bus_gnt) half <= ~half;
      if (retire) head <= bump(head);
      if (push)   tail <= bump(tail);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= st_addr;
      data_q[tail] <= st_data;
    end
  end
endmodule

// File: rtl/store_write_buffer_checks.sv
module store_write_buffer_checks #(
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_req,
  input logic          rd_req,
  input logic          cpu_stall,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic          bus_half,
  input logic [15:0]   bus_wdata,
  input logic          bus_gnt,
  input logic          idle
);
  assert_hold_no_gnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_half) && $stable(bus_wdata));

  assert_high_follows_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && !bus_half |=> bus_req && bus_half && $stable(bus_addr));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !bus_req && !bus_half);

  assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_req && !rd_req && cpu_stall |-> bus_req && !(bus_gnt && bus_half));

  assert_drain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_req && cpu_stall) && rd_req && !st_req && !idle |-> cpu_stall);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !st_req && idle |-> !cpu_stall);
endmodule

bind store_write_buffer store_write_buffer_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .st_req(st_req), .rd_req(rd_req),
  .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_addr(bus_addr),
  .bus_half(bus_half), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .idle(idle)
);

// File: tb/tb_store_write_buffer.sv
module tb_store_write_buffer;
  localparam int D  = 8;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_req = 1'b0, rd_req = 1'b0, bus_gnt = 1'b0;
  logic [AW-1:0] st_addr = '0, rd_addr = '0;
  logic [31:0]   st_data = '0;
  logic          cpu_stall, bus_req, bus_half, idle;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;

  store_write_buffer #(.DEPTH(D), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .cpu_stall(cpu_stall), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_half(bus_half), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .idle(idle)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [AW-1:0] qa [$];
  logic [31:0]   qd [$];
  bit m_half = 0, m_drain = 0, prev_wait = 0, last_stall = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input logic [AW-1:0] sa, input logic [31:0] sd,
                     input bit r, input logic [AW-1:0] ra, input bit g);
    bit hit, full, ret, e_stall;
    logic [15:0] e_data;
    st_req = s; st_addr = sa; st_data = sd; rd_req = r; rd_addr = ra; bus_gnt = g;
    #1;
    hit = 0;
    foreach (qa[i]) if (qa[i] == ra) hit = 1;
    full = (qa.size() == D);
    ret  = (qa.size() > 0) && g && m_half;
    e_stall = (r && (hit || m_drain)) || (s && full && !ret);
    chk(idle === (qa.size() == 0), "R8 idle", idle, qa.size() == 0);
    chk(bus_req === (qa.size() > 0), "R3 bus_req", bus_req, qa.size() > 0);
    if (qa.size() > 0) begin
      e_data = m_half ? qd[0][31:16] : qd[0][15:0];
      chk(bus_addr === qa[0] && bus_half === m_half && bus_wdata === e_data,
          prev_wait ? "R4 held bus" : "R3 bus beat",
          {bus_addr, bus_half, bus_wdata}, {qa[0], m_half, e_data});
    end
    if (s)
      chk(cpu_stall === e_stall, full ? "R7 store stall" : "R2 store accept", cpu_stall, e_stall);
    else if (r)
      chk(cpu_stall === e_stall, (hit || m_drain) ? "R5 read drain" : "R6 read miss", cpu_stall, e_stall);
    else
      chk(cpu_stall === 1'b0, "R2 quiet stall", cpu_stall, 0);
    last_stall = cpu_stall;
    prev_wait = (qa.size() > 0) && !g;
    if (qa.size() > 0 && g) m_half = !m_half;
    if (ret) begin qa.pop_front(); qd.pop_front(); end
    if (s && (!full || ret)) begin qa.push_back(sa); qd.push_back(sd); end
    m_drain = (m_drain || (r && hit)) && (qa.size() > 0);
    @(negedge clk);
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [31:0] d, input bit g);
    do cyc(1, a, d, 0, 0, g); while (last_stall);
  endtask

  task automatic read(input logic [AW-1:0] a, input int gper);
    int n = 0;
    do begin cyc(0, 0, 0, 1, a, (n % gper) == 0); n++; end while (last_stall);
  endtask

  task automatic idle_cycles(input int n, input bit g);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, g);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(idle === 1'b1 && bus_req === 1'b0 && cpu_stall === 1'b0, "R1 reset",
        {idle, bus_req, cpu_stall}, 3'b100);
    @(negedge clk);

    for (int i = 0; i < 6; i++) store(AW'(100 + i), 32'hA5A50000 + i * 32'h00010003, 1);
    idle_cycles(14, 1);

    for (int i = 0; i < D; i++) store(AW'(200 + i), 32'h12340000 + i, 0);
    for (int i = 0; i < 3; i++) cyc(1, 300, 32'hDEADBEEF, 0, 0, 0);
    cyc(1, 300, 32'hDEADBEEF, 0, 0, 1);
    cyc(1, 300, 32'hDEADBEEF, 0, 0, 1);
    idle_cycles(3, 0);
    read(999, 1);
    read(203, 2);
    chk(idle === 1'b1, "R5 drained fully", idle, 1);

    for (int i = 0; i < 4; i++) store(AW'(400 + i), 32'hCAFE0000 + i, 0);
    cyc(0, 0, 0, 0, 0, 1);
    read(400, 3);
    chk(idle === 1'b1, "R5 head hit drain", idle, 1);
    idle_cycles(3, 1);

    begin
      bit s, r;
      logic [AW-1:0] a;
      logic [31:0] d;
      s = 0; r = 0; a = '0; d = '0;
      for (int n = 0; n < 4000; n++) begin
        if (!last_stall) begin
          int k = $urandom_range(0, 9);
          s = (k < 5); r = (k >= 5 && k < 7);
          a = AW'($urandom_range(0, 15)); d = $urandom;
        end
        cyc(s, a, d, r, a, ($urandom_range(0, 2) == 0));
      end
    end
    idle_cycles(40, 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule